// File: doc/BRIEF.md
# Integer Execute Unit with Condition Bit

This block is the single-cycle integer execute stage of a 32-bit RISC core whose instructions are 16 bits wide. The issue logic presents the instruction word, the operand values already read for the two register fields (destination-side `rn` and source-side `rm`), the value of register 0 and the current condition bit. The block is purely combinational. In the same cycle it returns a result word, a register write enable with the destination index, a condition-bit write enable and the next value of the condition bit.

One condition bit serves several purposes. It is the carry into and out of the add-with-carry operation, the overflow flag of the checked add, and the outcome of every comparison. Each supported operation either leaves the bit alone, or writes it and/or the destination register. The supported operations are register and immediate adds, carry and overflow adds, equality and ordered compares, sign tests, a byte-lane match, a decrement-and-test, and four width extensions. Any other encoding writes nothing and passes the condition bit through unchanged.

Top module: `int_exec_unit`

## Requirements
- R1: Word `0011 nnnn mmmm 1100` asserts the register write with index `nnnn` and result rn+rm modulo 2^32; the condition bit is not written and `t_o` equals `t_i`.
- R2: Word `0111 nnnn iiii iiii` writes rn plus the 8-bit field sign-extended to 32 bits into index `nnnn`; the condition bit is not written.
- R3: Word `0011 nnnn mmmm 1110` writes rn+rm+`t_i` and writes the carry out of bit 31 into the condition bit.
- R4: Word `0011 nnnn mmmm 1111` writes rn+rm and sets the condition bit to 1 exactly when the signed sum overflows.
- R5: Word `1000 1000 iiii iiii` sets the condition bit to (r0 == sign-extended 8-bit field), and word `0011 nnnn mmmm 0000` sets it to (rn == rm).
- R6: Under prefix `0011`, low nibble `0010` gives rn >= rm unsigned, `0011` gives rn >= rm signed, `0110` gives rn > rm unsigned and `0111` gives rn > rm signed, each into the condition bit.
- R7: Word `0100 nnnn 0001 0101` sets the condition bit to (rn > 0 signed), and word `0100 nnnn 0001 0001` sets it to (bit 31 of rn is 0).
- R8: Word `0010 nnnn mmmm 1100` sets the condition bit to 1 when any of the four byte lanes of rn equals the same lane of rm.
- R9: Word `0100 nnnn 0001 0000` writes rn-1 to index `nnnn` and sets the condition bit to 1 exactly when that new value is zero.
- R10: Under prefix `0110`, low nibble `1110` sign-extends bits 7:0 of rm, `1111` sign-extends bits 15:0, `1100` zero-extends bits 7:0 and `1101` zero-extends bits 15:0. Each writes the value to index `nnnn` and leaves the condition bit unwritten.
- R11: Every compare of R5 to R8 asserts the condition write, deasserts the register write and drives `result_o` to zero.
- R12: Any encoding not listed in R1 to R10 deasserts both write enables, drives `result_o` to zero and passes `t_i` to `t_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Instruction word being executed |
| rn_val_i | input | 32 | Value of the register named by bits 11:8 |
| rm_val_i | input | 32 | Value of the register named by bits 7:4 |
| r0_val_i | input | 32 | Value of register 0 |
| t_i | input | 1 | Current condition bit |
| result_o | output | 32 | Value to write to the destination register |
| rd_we_o | output | 1 | Destination register write enable |
| rd_idx_o | output | 4 | Destination register index (bits 11:8) |
| t_we_o | output | 1 | Condition bit write enable |
| t_o | output | 1 | Next condition bit |

## Verification
The bench sweeps all 65536 instruction words with operands derived from the word. This separates the recognised encodings from their near neighbours and shows that no unlisted word writes anything. Every recognised operation is then crossed with a set of boundary operands (zero, one, all ones, the two sign-boundary values, byte and halfword sign edges, and words sharing exactly one byte lane) under both condition-bit values. These operands distinguish signed from unsigned ordering, expose carry and overflow at bit 31, hit the zero case of the decrement, and show which lane triggers a byte match.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

   typedef enum logic [4:0] {
      OP_NONE,
      OP_ADD_RR,
      OP_ADD_RI,
      OP_ADD_CIN,
      OP_ADD_OVF,
      OP_EQ_IMM,
      OP_EQ_RR,
      OP_GE_U,
      OP_GE_S,
      OP_GT_U,
      OP_GT_S,
      OP_POS,
      OP_NONNEG,
      OP_BYTE_HIT,
      OP_DEC_TEST,
      OP_SX8,
      OP_SX16,
      OP_ZX8,
      OP_ZX16
   } op_e;

   function automatic logic op_is_compare(op_e op);
      return op inside {OP_EQ_IMM, OP_EQ_RR, OP_GE_U, OP_GE_S, OP_GT_U,
                        OP_GT_S, OP_POS, OP_NONNEG, OP_BYTE_HIT};
   endfunction

   function automatic logic op_is_add(op_e op);
      return op inside {OP_ADD_RR, OP_ADD_RI, OP_ADD_CIN, OP_ADD_OVF, OP_DEC_TEST};
   endfunction

   function automatic logic op_is_ext(op_e op);
      return op inside {OP_SX8, OP_SX16, OP_ZX8, OP_ZX16};
   endfunction

   function automatic logic op_writes_reg(op_e op);
      return op_is_add(op) || op_is_ext(op);
   endfunction

   function automatic logic op_writes_t(op_e op);
      return op_is_compare(op) || op inside {OP_ADD_CIN, OP_ADD_OVF, OP_DEC_TEST};
   endfunction

endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
   import iexu_pkg::*;
#(
   parameter int INSTR_W = 16
) (
   input  logic [INSTR_W-1:0] instr_i,
   output op_e                op_o
);

   localparam int TOP_LO = INSTR_W - 4;

   logic [3:0] major;
   logic [3:0] field_n;
   logic [3:0] minor;
   logic [7:0] low_byte;

   assign major    = instr_i[INSTR_W-1:TOP_LO];
   assign field_n  = instr_i[11:8];
   assign minor    = instr_i[3:0];
   assign low_byte = instr_i[7:0];

   always_comb begin
      op_o = OP_NONE;
      case (major)
         4'h3: begin
            case (minor)
               4'hC:    op_o = OP_ADD_RR;
               4'hE:    op_o = OP_ADD_CIN;
               4'hF:    op_o = OP_ADD_OVF;
               4'h0:    op_o = OP_EQ_RR;
               4'h2:    op_o = OP_GE_U;
               4'h3:    op_o = OP_GE_S;
               4'h6:    op_o = OP_GT_U;
               4'h7:    op_o = OP_GT_S;
               default: op_o = OP_NONE;
            endcase
         end
         4'h7: op_o = OP_ADD_RI;
         4'h8: if (field_n == 4'h8) op_o = OP_EQ_IMM;
         4'h4: begin
            case (low_byte)
               8'h15:   op_o = OP_POS;
               8'h11:   op_o = OP_NONNEG;
               8'h10:   op_o = OP_DEC_TEST;
               default: op_o = OP_NONE;
            endcase
         end
         4'h2: if (minor == 4'hC) op_o = OP_BYTE_HIT;
         4'h6: begin
            case (minor)
               4'hE:    op_o = OP_SX8;
               4'hF:    op_o = OP_SX16;
               4'hC:    op_o = OP_ZX8;
               4'hD:    op_o = OP_ZX16;
               default: op_o = OP_NONE;
            endcase
         end
         default: op_o = OP_NONE;
      endcase
   end

   // R12: the immediate-add and immediate-compare classes never overlap another prefix
   always_comb begin
      p_prefix_r12: assert (!(op_o == OP_ADD_RI) || major == 4'h7)
         else $error("immediate add decoded outside its prefix");
   end

endmodule

// File: rtl/iexu_adder.sv
module iexu_adder #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o,
   output logic         ovf_o
);

   logic [W:0] wide;

   assign wide   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
   assign sum_o  = wide[W-1:0];
   assign cout_o = wide[W];
   assign ovf_o  = (a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1]);

   logic [W:0] sext_sum;
   assign sext_sum = {a_i[W-1], a_i} + {b_i[W-1], b_i} + {{W{1'b0}}, cin_i};

   // R4: overflow agrees with a sign-extended reference sum
   always_comb begin
      p_ovf_match_r4: assert (ovf_o == (sext_sum[W] != sext_sum[W-1]))
         else $error("overflow flag disagrees with widened sum");
   end

endmodule

// File: rtl/iexu_compare.sv
module iexu_compare #(
   parameter int W            = 32,
   parameter bit CMP_FROM_SUB = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         eq_o,
   output logic         ge_u_o,
   output logic         ge_s_o,
   output logic         gt_u_o,
   output logic         gt_s_o,
   output logic         pos_o,
   output logic         nonneg_o,
   output logic         byte_hit_o
);

   localparam int LANES = W / 8;

   logic [LANES-1:0] lane_eq;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_eq[g] = (a_i[g*8 +: 8] == b_i[g*8 +: 8]);
   end

   assign byte_hit_o = |lane_eq;
   assign nonneg_o   = ~a_i[W-1];
   assign pos_o      = ~a_i[W-1] && (|a_i);

   if (CMP_FROM_SUB) begin : g_sub
      logic [W:0] diff;
      logic       v;
      assign diff   = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};
      assign eq_o   = (diff[W-1:0] == '0);
      assign ge_u_o = diff[W];
      assign gt_u_o = diff[W] & ~eq_o;
      assign v      = (a_i[W-1] != b_i[W-1]) && (diff[W-1] != a_i[W-1]);
      assign ge_s_o = (diff[W-1] == v);
      assign gt_s_o = ge_s_o & ~eq_o;

      // R6: flag-derived orderings agree with relational operators
      always_comb begin
         p_ge_u_r6: assert (ge_u_o == (a_i >= b_i))
            else $error("unsigned ordering from borrow is wrong");
         p_gt_s_r6: assert (gt_s_o == ($signed(a_i) > $signed(b_i)))
            else $error("signed ordering from flags is wrong");
      end
   end else begin : g_rel
      assign eq_o   = (a_i == b_i);
      assign ge_u_o = (a_i >= b_i);
      assign gt_u_o = (a_i > b_i);
      assign ge_s_o = ($signed(a_i) >= $signed(b_i));
      assign gt_s_o = ($signed(a_i) > $signed(b_i));
   end

   // R8: equality of the whole word implies a lane match
   always_comb begin
      p_lane_r8: assert (!eq_o || byte_hit_o)
         else $error("equal words without a byte lane match");
   end

endmodule

// File: rtl/iexu_extend.sv
module iexu_extend #(
   parameter int W = 32
) (
   input  logic [W-1:0] src_i,
   input  logic         half_i,
   input  logic         signed_i,
   output logic [W-1:0] val_o
);

   logic fill8;
   logic fill16;

   assign fill8  = signed_i & src_i[7];
   assign fill16 = signed_i & src_i[15];

   always_comb begin
      if (half_i) val_o = {{(W-16){fill16}}, src_i[15:0]};
      else        val_o = {{(W-8){fill8}},   src_i[7:0]};
   end

   // R10: the retained low bits always match the source
   always_comb begin
      p_low_keep_r10: assert (val_o[7:0] == src_i[7:0])
         else $error("extension altered the low byte");
   end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
   import iexu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int INSTR_W      = 16,
   parameter int IDX_W        = 4,
   parameter bit CMP_FROM_SUB = 1'b1
) (
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [DATA_W-1:0]  rn_val_i,
   input  logic [DATA_W-1:0]  rm_val_i,
   input  logic [DATA_W-1:0]  r0_val_i,
   input  logic               t_i,
   output logic [DATA_W-1:0]  result_o,
   output logic               rd_we_o,
   output logic [IDX_W-1:0]   rd_idx_o,
   output logic               t_we_o,
   output logic               t_o
);

   localparam int IMM_W = 8;
   localparam int IDX_LO = 8;

   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if (INSTR_W != 16) begin : g_bad_instr
      $error("INSTR_W must be 16 for this encoding");
   end
   if (IDX_W != 4) begin : g_bad_idx
      $error("IDX_W must be 4 for this encoding");
   end

   op_e op;

   iexu_decode #(.INSTR_W(INSTR_W)) u_decode (
      .instr_i (instr_i),
      .op_o    (op)
   );

   logic [DATA_W-1:0] imm_sx;
   assign imm_sx = {{(DATA_W-IMM_W){instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};

   // adder operand steering
   logic [DATA_W-1:0] add_b;
   logic              add_cin;
   logic [DATA_W-1:0] add_sum;
   logic              add_cout;
   logic              add_ovf;

   always_comb begin
      case (op)
         OP_ADD_RI:   add_b = imm_sx;
         OP_DEC_TEST: add_b = '1;
         default:     add_b = rm_val_i;
      endcase
      add_cin = (op == OP_ADD_CIN) ? t_i : 1'b0;
   end

   iexu_adder #(.W(DATA_W)) u_adder (
      .a_i    (rn_val_i),
      .b_i    (add_b),
      .cin_i  (add_cin),
      .sum_o  (add_sum),
      .cout_o (add_cout),
      .ovf_o  (add_ovf)
   );

   // compare operand steering
   logic [DATA_W-1:0] cmp_a;
   logic [DATA_W-1:0] cmp_b;
   logic c_eq, c_ge_u, c_ge_s, c_gt_u, c_gt_s, c_pos, c_nonneg, c_byte;

   assign cmp_a = (op == OP_EQ_IMM) ? r0_val_i : rn_val_i;
   assign cmp_b = (op == OP_EQ_IMM) ? imm_sx   : rm_val_i;

   iexu_compare #(.W(DATA_W), .CMP_FROM_SUB(CMP_FROM_SUB)) u_compare (
      .a_i        (cmp_a),
      .b_i        (cmp_b),
      .eq_o       (c_eq),
      .ge_u_o     (c_ge_u),
      .ge_s_o     (c_ge_s),
      .gt_u_o     (c_gt_u),
      .gt_s_o     (c_gt_s),
      .pos_o      (c_pos),
      .nonneg_o   (c_nonneg),
      .byte_hit_o (c_byte)
   );

   logic [DATA_W-1:0] ext_val;

   iexu_extend #(.W(DATA_W)) u_extend (
      .src_i    (rm_val_i),
      .half_i   (op == OP_SX16 || op == OP_ZX16),
      .signed_i (op == OP_SX8 || op == OP_SX16),
      .val_o    (ext_val)
   );

   // result and enables
   always_comb begin
      if (op_is_add(op))      result_o = add_sum;
      else if (op_is_ext(op)) result_o = ext_val;
      else                    result_o = '0;
   end

   assign rd_we_o  = op_writes_reg(op);
   assign t_we_o   = op_writes_t(op);
   assign rd_idx_o = instr_i[IDX_LO +: IDX_W];

   always_comb begin
      case (op)
         OP_ADD_CIN:  t_o = add_cout;
         OP_ADD_OVF:  t_o = add_ovf;
         OP_EQ_IMM,
         OP_EQ_RR:    t_o = c_eq;
         OP_GE_U:     t_o = c_ge_u;
         OP_GE_S:     t_o = c_ge_s;
         OP_GT_U:     t_o = c_gt_u;
         OP_GT_S:     t_o = c_gt_s;
         OP_POS:      t_o = c_pos;
         OP_NONNEG:   t_o = c_nonneg;
         OP_BYTE_HIT: t_o = c_byte;
         OP_DEC_TEST: t_o = (add_sum == '0);
         default:     t_o = t_i;
      endcase
   end

   always_comb begin
      p_idle_r12: assert (op != OP_NONE || (!rd_we_o && !t_we_o && t_o == t_i && result_o == '0))
         else $error("unrecognised opcode produced an effect");
      p_cmp_nowrite_r11: assert (!op_is_compare(op) || (!rd_we_o && t_we_o && result_o == '0))
         else $error("compare wrote a register");
      p_dec_zero_r9: assert (op != OP_DEC_TEST || (t_o == (result_o == '0) && result_o == rn_val_i - 1'b1))
         else $error("decrement test flag or value wrong");
      p_t_hold_r1: assert (t_we_o || t_o == t_i)
         else $error("condition bit moved without write enable");
   end

endmodule

// File: tb/test_int_exec_unit.sv
module test_int_exec_unit;

   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [15:0]  instr;
   logic [W-1:0] rn, rm, r0;
   logic         t_in;
   logic [W-1:0] result;
   logic         rd_we, t_we, t_out;
   logic [3:0]   rd_idx;

   int unsigned n_checks = 0;
   int unsigned n_errs   = 0;
   bit          finished = 1'b0;

   int_exec_unit i_int_exec_unit (
      .instr_i  (instr),
      .rn_val_i (rn),
      .rm_val_i (rm),
      .r0_val_i (r0),
      .t_i      (t_in),
      .result_o (result),
      .rd_we_o  (rd_we),
      .rd_idx_o (rd_idx),
      .t_we_o   (t_we),
      .t_o      (t_out)
   );

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
   endtask

   // expected behaviour written from the requirement encodings
   task automatic model(input logic [15:0] ins, input logic [W-1:0] a, b, z, input logic t,
                        output logic we, output logic twe, output logic tn,
                        output logic [W-1:0] res, output string tag);
      logic [W-1:0] imm;
      logic [W:0]   s;
      imm = {{24{ins[7]}}, ins[7:0]};
      we = 0; twe = 0; tn = t; res = '0; tag = "R12";
      case (ins[15:12])
         4'h3: case (ins[3:0])
            4'hC: begin tag = "R1"; we = 1; res = a + b; end
            4'hE: begin tag = "R3"; we = 1; twe = 1; s = {1'b0,a} + {1'b0,b} + t; res = s[W-1:0]; tn = s[W]; end
            4'hF: begin tag = "R4"; we = 1; twe = 1; res = a + b;
                        tn = (a[31] == b[31]) && (res[31] != a[31]); end
            4'h0: begin tag = "R5"; twe = 1; tn = (a == b); end
            4'h2: begin tag = "R6"; twe = 1; tn = (a >= b); end
            4'h3: begin tag = "R6"; twe = 1; tn = ($signed(a) >= $signed(b)); end
            4'h6: begin tag = "R6"; twe = 1; tn = (a > b); end
            4'h7: begin tag = "R6"; twe = 1; tn = ($signed(a) > $signed(b)); end
            default: ;
         endcase
         4'h7: begin tag = "R2"; we = 1; res = a + imm; end
         4'h8: if (ins[11:8] == 4'h8) begin tag = "R5"; twe = 1; tn = (z == imm); end
         4'h4: case (ins[7:0])
            8'h15: begin tag = "R7"; twe = 1; tn = ($signed(a) > 0); end
            8'h11: begin tag = "R7"; twe = 1; tn = !a[31]; end
            8'h10: begin tag = "R9"; we = 1; twe = 1; res = a - 1; tn = (res == 0); end
            default: ;
         endcase
         4'h2: if (ins[3:0] == 4'hC) begin
            tag = "R8"; twe = 1;
            tn = (a[7:0] == b[7:0]) || (a[15:8] == b[15:8]) ||
                 (a[23:16] == b[23:16]) || (a[31:24] == b[31:24]);
         end
         4'h6: case (ins[3:0])
            4'hE: begin tag = "R10"; we = 1; res = {{24{b[7]}}, b[7:0]}; end
            4'hF: begin tag = "R10"; we = 1; res = {{16{b[15]}}, b[15:0]}; end
            4'hC: begin tag = "R10"; we = 1; res = {24'h0, b[7:0]}; end
            4'hD: begin tag = "R10"; we = 1; res = {16'h0, b[15:0]}; end
            default: ;
         endcase
         default: ;
      endcase
      if (twe && !we && tag != "R12" && tag != "R9") tag = {tag, "/R11"};
   endtask

   task automatic run_one(input logic [15:0] ins, input logic [W-1:0] a, b, z, input logic t);
      logic we_e, twe_e, tn_e;
      logic [W-1:0] res_e;
      string tag;
      @(negedge clk);
      instr = ins; rn = a; rm = b; r0 = z; t_in = t;
      #1;
      model(ins, a, b, z, t, we_e, twe_e, tn_e, res_e, tag);
      n_checks++;
      if (rd_we !== we_e || t_we !== twe_e || t_out !== tn_e || result !== res_e ||
          (we_e && rd_idx !== ins[11:8])) begin
         n_errs++;
         $display("FAIL %s instr=%h rn=%h rm=%h r0=%h t=%b got we=%b twe=%b t=%b res=%h idx=%h exp we=%b twe=%b t=%b res=%h idx=%h",
                  tag, ins, a, b, z, t, rd_we, t_we, t_out, result, rd_idx,
                  we_e, twe_e, tn_e, res_e, ins[11:8]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_errs++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   logic [W-1:0] vals [12] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0002,
                               32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
                               32'h0000_00FF, 32'h0000_0080, 32'h0000_8000,
                               32'h1234_5678, 32'hA534_C3FF, 32'h0000_7FFF};

   logic [15:0] ops [20] = '{16'h35AC, 16'h7A80, 16'h712C, 16'h37BE, 16'h3C4F,
                             16'h88FF, 16'h8805, 16'h3120, 16'h3342, 16'h3453,
                             16'h3566, 16'h3677, 16'h4915, 16'h4211, 16'h2D3C,
                             16'h4E10, 16'h601E, 16'h6F2F, 16'h674C, 16'h6B5D};

   initial begin
      instr = 16'h0000; rn = '0; rm = '0; r0 = '0; t_in = 1'b0;
      // idle state with an unrecognised word (R12)
      run_one(16'h0000, 32'h0, 32'h0, 32'h0, 1'b1);
      // every instruction word, operands derived from the word (R1..R12 decode)
      for (int k = 0; k < 65536; k++) begin
         logic [W-1:0] a;
         a = k * 32'h9E37_79B1;
         run_one(k[15:0], a, a ^ {k[15:0], k[7:0], k[15:8]}, ~a, k[0] ^ k[5]);
      end
      // boundary operand crosses for each operation (R1..R11)
      for (int o = 0; o < 20; o++)
         for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
               for (int t = 0; t < 2; t++)
                  run_one(ops[o], vals[i], vals[j], vals[j], t[0]);
      // R8 single-lane matches, R9 zero crossing, R5 immediate sign extension
      for (int l = 0; l < 4; l++)
         run_one(16'h201C, 32'h1111_1111 ^ (32'hEE << (8*l)), 32'hFFFF_FFFF, 32'h0, 1'b0);
      run_one(16'h4310, 32'h1, 32'h0, 32'h0, 1'b0);
      run_one(16'h4310, 32'h0, 32'h0, 32'h0, 1'b1);
      run_one(16'h8880, 32'h0, 32'h0, 32'hFFFF_FF80, 1'b0);
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule